// File: doc/BRIEF.md
# Snooping MOESI Line-State Controller with Owner-Broadcast Stores

This block is the coherence controller of one core's private cache. It keeps a five-state tag directory (Modified, Owned, Exclusive, Shared, Invalid) for a set-associative cache. It serves the core's loads and stores, and it snoops the transactions that other cores place on a shared bus. It decides which bus transaction each local access needs. Stores normally cost an invalidate broadcast. A store to a line this cache holds as Owned instead broadcasts the new value as an update, and the line stays Owned. The protocol therefore mixes update and invalidate traffic.

The bus slot is atomic. A local request is decided in the same cycle it is presented. The transaction it needs is driven combinationally on the `tx_*` outputs. The wired-OR "another copy exists" answer comes back on `tx_shared_in` in that same cycle, and the directory updates at the next rising edge. A snoop has priority over a local request and holds the core off for that cycle. The data arrays live outside this block. Only the store value is carried through on `tx_data` so that an update broadcast can deliver it. Counters report read, invalidate, update and writeback traffic, together with their sum.

Top module: `moesi_owned_update_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every line is Invalid and all five traffic counters read zero.
- R2: A load that hits raises no transaction. A load that misses raises `tx_op` = 0 (read) and allocates the line: Exclusive if `tx_shared_in` is low in that cycle, Shared if it is high.
- R3: A store to a Modified or Exclusive line raises no transaction and leaves the line Modified.
- R4: A store to an Owned line raises `tx_op` = 2 (update) carrying the store address and data, and the line stays Owned.
- R5: A store to a Shared line, or a store that misses, raises `tx_op` = 1 (invalidate), and the line ends Modified.
- R6: A snooped read (`snp_op` = 0) that hits raises `snp_shared`, and also raises `snp_supply` if the copy is Modified or Owned. It moves Modified to Owned and Exclusive to Shared.
- R7: A snooped invalidate (`snp_op` = 1) that hits makes the local copy Invalid.
- R8: A snooped update (`snp_op` = 2) leaves the local state unchanged, so a Shared copy stays Shared.
- R9: A snoop whose `snp_core` equals the block's own core ID has no effect and raises neither snoop output.
- R10: On a miss, the lowest-numbered Invalid way of the set is filled first. If no way is Invalid, the least recently used way is replaced. Only local accesses update recency.
- R11: Replacing a Modified or Owned line raises `wb_valid` with the victim's address in the same cycle as the miss. Replacing an Exclusive or Shared line raises no writeback.
- R12: Each raised read, invalidate, update and writeback increments its own counter. `cnt_total` always equals the sum of the four.
- R13: While `snp_valid` is high, `req_ready` is low and the local request is neither performed nor issued on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Line address of the request |
| req_wdata | input | DATA_W | Store value |
| req_ready | output | 1 | Request is taken this cycle |
| tx_valid | output | 1 | Local bus transaction this cycle |
| tx_op | output | 2 | 0 read, 1 invalidate, 2 update |
| tx_core | output | CORE_W | This core's ID on the bus |
| tx_addr | output | ADDR_W | Transaction line address |
| tx_data | output | DATA_W | Update payload |
| tx_shared_in | input | 1 | Another cache holds the line (same cycle) |
| wb_valid | output | 1 | Dirty victim writeback this cycle |
| wb_addr | output | ADDR_W | Victim line address |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_op | input | 2 | Snooped operation, same encoding as tx_op |
| snp_core | input | CORE_W | Issuing core of the snooped transaction |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds a valid copy |
| snp_supply | output | 1 | This cache supplies data for a snooped read |
| cnt_read | output | CNT_W | Reads issued |
| cnt_inv | output | CNT_W | Invalidates issued |
| cnt_upd | output | CNT_W | Updates issued |
| cnt_wb | output | CNT_W | Writebacks issued |
| cnt_total | output | CNT_W | Sum of the four counters |

## Verification
Because state is internal, a wrong state shows up only at the next access to the same line. A store then raises the wrong transaction kind, or a snooped read raises or drops `snp_supply`, or a load misses when it should hit. The bench therefore follows each state change with the store, load or snoop that tells the states apart, one or two cycles later. Recency errors surface later still, as a wrong victim address or a missing or extra writeback on the fifth distinct line of a set. Counter errors show only in the final comparison with the bench's own tally.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } mstate_e;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_INV  = 2'd1,
        OP_UPD  = 2'd2,
        OP_WB   = 2'd3
    } bus_op_e;

    function automatic logic is_dirty(mstate_e s);
        return (s == ST_M) || (s == ST_O);
    endfunction

    // next state of a held copy after another core's bus transaction
    function automatic mstate_e snoop_next(mstate_e s, bus_op_e op);
        mstate_e n;
        n = s;
        case (op)
            OP_READ: begin
                if (s == ST_M) n = ST_O;
                else if (s == ST_E) n = ST_S;
            end
            OP_INV:  n = ST_I;
            default: n = s;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/moesi_lookup.sv
module moesi_lookup
    import moesi_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    parameter int WAY_W = 2
) (
    input  mstate_e              way_st  [WAYS],
    input  logic [TAG_W-1:0]     way_tag [WAYS],
    input  logic [TAG_W-1:0]     key,
    output logic                 hit,
    output logic [WAY_W-1:0]     hit_way,
    output mstate_e              hit_st
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = (way_st[w] != ST_I) && (way_tag[w] == key);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        hit_st  = ST_I;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way = WAY_W'(w);
                hit_st  = way_st[w];
            end
        end
    end

endmodule

// File: rtl/moesi_victim.sv
module moesi_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WAY_W-1:0]     ages [WAYS],
    input  logic [WAYS-1:0]      free,
    output logic                 has_free,
    output logic [WAY_W-1:0]     victim
);

    always_comb begin
        has_free = |free;
        victim   = '0;
        if (has_free) begin
            for (int w = WAYS - 1; w >= 0; w--)
                if (free[w]) victim = WAY_W'(w);
        end else begin
            for (int w = 0; w < WAYS; w++)
                if (ages[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
        end
    end

    AST_VICTIM_IS_OLDEST: assert property (@(posedge clk) disable iff (rst)
        !has_free |-> (ages[victim] == WAY_W'(WAYS - 1))); // R10
    AST_VICTIM_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
        has_free |-> free[victim]); // R10

endmodule

// File: rtl/moesi_traffic_cnt.sv
module moesi_traffic_cnt
    import moesi_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_valid,
    input  bus_op_e          tx_op,
    input  logic             wb_valid,
    output logic [CNT_W-1:0] cnt_read,
    output logic [CNT_W-1:0] cnt_inv,
    output logic [CNT_W-1:0] cnt_upd,
    output logic [CNT_W-1:0] cnt_wb,
    output logic [CNT_W-1:0] cnt_total
);

    logic [1:0] step;
    assign step = 2'(tx_valid) + 2'(wb_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_read  <= '0;
            cnt_inv   <= '0;
            cnt_upd   <= '0;
            cnt_wb    <= '0;
            cnt_total <= '0;
        end else begin
            if (tx_valid && tx_op == OP_READ) cnt_read <= cnt_read + 1'b1;
            if (tx_valid && tx_op == OP_INV)  cnt_inv  <= cnt_inv + 1'b1;
            if (tx_valid && tx_op == OP_UPD)  cnt_upd  <= cnt_upd + 1'b1;
            if (wb_valid)                     cnt_wb   <= cnt_wb + 1'b1;
            cnt_total <= cnt_total + CNT_W'(step);
        end
    end

    AST_TOTAL_IS_SUM: assert property (@(posedge clk) disable iff (rst)
        cnt_total == CNT_W'(cnt_read + cnt_inv + cnt_upd + cnt_wb)); // R12

endmodule

// File: rtl/moesi_owned_update_ctrl.sv
module moesi_owned_update_ctrl
    import moesi_pkg::*;
#(
    parameter int CORE_ID = 0,
    parameter int CORE_W  = 4,
    parameter int ADDR_W  = 16,
    parameter int SETS    = 64,
    parameter int WAYS    = 4,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              tx_valid,
    output logic [1:0]        tx_op,
    output logic [CORE_W-1:0] tx_core,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_shared_in,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [CORE_W-1:0] snp_core,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [CNT_W-1:0]  cnt_read,
    output logic [CNT_W-1:0]  cnt_inv,
    output logic [CNT_W-1:0]  cnt_upd,
    output logic [CNT_W-1:0]  cnt_wb,
    output logic [CNT_W-1:0]  cnt_total
);

    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    mstate_e          st_q  [SETS][WAYS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    // one lookup port, shared by snoop (priority) and local request
    logic              snp_act, local_go;
    logic [ADDR_W-1:0] op_addr;
    logic [SET_W-1:0]  op_set;
    logic [TAG_W-1:0]  op_tag;

    assign snp_act   = snp_valid && (snp_core != CORE_W'(CORE_ID));
    assign local_go  = req_valid && !snp_valid;
    assign req_ready = !snp_valid;
    assign op_addr   = snp_valid ? snp_addr : req_addr;
    assign op_set    = op_addr[SET_W-1:0];
    assign op_tag    = op_addr[ADDR_W-1:SET_W];

    mstate_e          set_st  [WAYS];
    logic [TAG_W-1:0] set_tag [WAYS];
    logic [WAY_W-1:0] set_age [WAYS];
    logic [WAYS-1:0]  set_free;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_st[w]   = st_q[op_set][w];
            set_tag[w]  = tag_q[op_set][w];
            set_age[w]  = age_q[op_set][w];
            set_free[w] = (st_q[op_set][w] == ST_I);
        end
    end

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    mstate_e          hit_st;
    logic             has_free;
    logic [WAY_W-1:0] victim;

    moesi_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
        .way_st(set_st), .way_tag(set_tag), .key(op_tag),
        .hit(hit), .hit_way(hit_way), .hit_st(hit_st)
    );

    moesi_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .clk(clk), .rst(rst), .ages(set_age), .free(set_free),
        .has_free(has_free), .victim(victim)
    );

    // local access decision
    bus_op_e          op_sel;
    logic             alloc;
    mstate_e          nxt_st;
    logic [WAY_W-1:0] tgt_way;

    always_comb begin
        tx_valid = 1'b0;
        op_sel   = OP_READ;
        wb_valid = 1'b0;
        alloc    = 1'b0;
        nxt_st   = hit_st;
        tgt_way  = hit_way;
        if (local_go) begin
            if (hit) begin
                if (req_write) begin
                    case (hit_st)
                        ST_O: begin tx_valid = 1'b1; op_sel = OP_UPD; nxt_st = ST_O; end
                        ST_S: begin tx_valid = 1'b1; op_sel = OP_INV; nxt_st = ST_M; end
                        default: nxt_st = ST_M;
                    endcase
                end
            end else begin
                alloc    = 1'b1;
                tgt_way  = victim;
                wb_valid = is_dirty(set_st[victim]);
                tx_valid = 1'b1;
                if (req_write) begin
                    op_sel = OP_INV;
                    nxt_st = ST_M;
                end else begin
                    op_sel = OP_READ;
                    nxt_st = tx_shared_in ? ST_S : ST_E;
                end
            end
        end
    end

    assign tx_op      = op_sel;
    assign tx_core    = CORE_W'(CORE_ID);
    assign tx_addr    = req_addr;
    assign tx_data    = req_wdata;
    assign wb_addr    = {set_tag[victim], op_set};
    assign snp_shared = snp_act && hit;
    assign snp_supply = snp_act && hit && is_dirty(hit_st) && (bus_op_e'(snp_op) == OP_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_q[s][w]  <= ST_I;
                    tag_q[s][w] <= '0;
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (local_go) begin
            st_q[op_set][tgt_way] <= nxt_st;
            if (alloc) tag_q[op_set][tgt_way] <= op_tag;
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == tgt_way)
                    age_q[op_set][w] <= '0;
                else if (set_age[w] < set_age[tgt_way])
                    age_q[op_set][w] <= set_age[w] + 1'b1;
            end
        end else if (snp_act && hit) begin
            st_q[op_set][hit_way] <= snoop_next(hit_st, bus_op_e'(snp_op));
        end
    end

    moesi_traffic_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_op(op_sel), .wb_valid(wb_valid),
        .cnt_read(cnt_read), .cnt_inv(cnt_inv), .cnt_upd(cnt_upd),
        .cnt_wb(cnt_wb), .cnt_total(cnt_total)
    );

    AST_UPD_STAYS_OWNED: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && op_sel == OP_UPD) |=> (st_q[$past(op_set)][$past(tgt_way)] == ST_O)); // R4
    AST_EXCL_STORE_DIRTIES: assert property (@(posedge clk) disable iff (rst)
        (local_go && req_write && hit && hit_st == ST_E) |=> (st_q[$past(op_set)][$past(hit_way)] == ST_M)); // R3
    AST_SNP_INV_DROPS: assert property (@(posedge clk) disable iff (rst)
        (snp_act && hit && bus_op_e'(snp_op) == OP_INV) |=> (st_q[$past(op_set)][$past(hit_way)] == ST_I)); // R7
    AST_SUPPLY_NEEDS_COPY: assert property (@(posedge clk) disable iff (rst)
        snp_supply |-> snp_shared); // R6
    AST_WB_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (tx_valid && op_sel != OP_UPD)); // R11
    AST_SNOOP_BLOCKS_LOCAL: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> (!tx_valid && !wb_valid)); // R13

endmodule

// File: tb/moesi_owned_update_ctrl_tb.sv
module moesi_owned_update_ctrl_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic       req_ready;
    logic       tx_valid;
    logic [1:0] tx_op;
    logic [3:0] tx_core;
    logic [7:0] tx_addr, tx_data;
    logic       tx_shared_in = 1'b0;
    logic       wb_valid;
    logic [7:0] wb_addr;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_op = '0;
    logic [3:0] snp_core = '0;
    logic [7:0] snp_addr = '0;
    logic       snp_shared, snp_supply;
    logic [15:0] cnt_read, cnt_inv, cnt_upd, cnt_wb, cnt_total;

    always #(CLK_P/2) clk = ~clk;

    moesi_owned_update_ctrl #(
        .CORE_ID(0), .CORE_W(4), .ADDR_W(8), .SETS(4), .WAYS(4), .DATA_W(8), .CNT_W(16)
    ) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .tx_valid(tx_valid), .tx_op(tx_op), .tx_core(tx_core), .tx_addr(tx_addr),
        .tx_data(tx_data), .tx_shared_in(tx_shared_in),
        .wb_valid(wb_valid), .wb_addr(wb_addr),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_core(snp_core), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_supply(snp_supply),
        .cnt_read(cnt_read), .cnt_inv(cnt_inv), .cnt_upd(cnt_upd),
        .cnt_wb(cnt_wb), .cnt_total(cnt_total)
    );

    int  n_chk = 0, n_fail = 0;
    int  e_rd = 0, e_inv = 0, e_upd = 0, e_wb = 0;
    bit  done = 1'b0;

    task automatic chk(input string r, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    function automatic int mk(input int t, input int s);
        return (t << 2) | s;
    endfunction

    // eop: -1 none, 0 read, 1 invalidate, 2 update
    task automatic req(input bit w, input int a, input int d, input bit sh,
                       input int eop, input bit ewb, input int ewba, input string r);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = 8'(a); req_wdata = 8'(d);
        tx_shared_in = sh;
        #(CLK_P/4);
        chk(r, "tx_valid", int'(tx_valid), int'(eop >= 0));
        if (eop >= 0) begin
            chk(r, "tx_op", int'(tx_op), eop);
            chk(r, "tx_addr", int'(tx_addr), a);
            if (eop == 2) chk(r, "tx_data", int'(tx_data), d);
        end
        chk(r, "wb_valid", int'(wb_valid), int'(ewb));
        if (ewb) chk(r, "wb_addr", int'(wb_addr), ewba);
        if (eop == 0) e_rd++;
        if (eop == 1) e_inv++;
        if (eop == 2) e_upd++;
        if (ewb) e_wb++;
        @(posedge clk);
        #1;
        req_valid = 1'b0; tx_shared_in = 1'b0;
    endtask

    task automatic snp(input int op, input int core, input int a,
                       input bit esh, input bit esup, input string r);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = 2'(op); snp_core = 4'(core); snp_addr = 8'(a);
        #(CLK_P/4);
        chk(r, "snp_shared", int'(snp_shared), int'(esh));
        chk(r, "snp_supply", int'(snp_supply), int'(esup));
        chk("R13", "req_ready", int'(req_ready), 0);
        @(posedge clk);
        #1;
        snp_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "cnt_total", int'(cnt_total), 0);
        chk("R1", "cnt_read", int'(cnt_read), 0);
        chk("R1", "req_ready", int'(req_ready), 1);
        for (int s = 0; s < 4; s++) snp(0, 1, mk(5, s), 1'b0, 1'b0, "R1");

        // R13: snoop holds off a concurrent request, which leaves no trace
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'(mk(40, 0));
        snp_valid = 1'b1; snp_op = 2'd0; snp_core = 4'd1; snp_addr = 8'(mk(41, 0));
        #(CLK_P/4);
        chk("R13", "req_ready", int'(req_ready), 0);
        chk("R13", "tx_valid", int'(tx_valid), 0);
        @(posedge clk);
        #1 req_valid = 1'b0; snp_valid = 1'b0;
        req(0, mk(40, 0), 0, 0, 0, 0, 0, "R13");   // still a miss
        snp(1, 1, mk(40, 0), 1'b1, 1'b0, "R7");    // clear it again

        for (int s = 0; s < 4; s++) begin
            req(0, mk(1, s), 0, 0, 0, 0, 0, "R2");           // miss -> E
            req(0, mk(1, s), 0, 0, -1, 0, 0, "R2");          // hit
            req(1, mk(1, s), 8'h11 + s, 0, -1, 0, 0, "R3");  // E -> M silent
            snp(0, 1, mk(1, s), 1'b1, 1'b1, "R6");           // M -> O, supplies
            req(1, mk(1, s), 8'h20 + s, 0, 2, 0, 0, "R4");   // owned store -> update
            req(1, mk(1, s), 8'h30 + s, 0, 2, 0, 0, "R4");   // still owned
            snp(0, 2, mk(1, s), 1'b1, 1'b1, "R6");           // owned still supplies
            snp(1, 2, mk(1, s), 1'b1, 1'b0, "R7");           // -> I
            req(0, mk(1, s), 0, 1, 0, 0, 0, "R7");           // misses, -> S
            snp(2, 3, mk(1, s), 1'b1, 1'b0, "R8");           // update: stays S
            snp(0, 3, mk(1, s), 1'b1, 1'b0, "R8");           // S: no supply
            snp(1, 0, mk(1, s), 1'b0, 1'b0, "R9");           // own ID ignored
            req(1, mk(1, s), 8'h40, 0, 1, 0, 0, "R5");       // S store -> invalidate
            req(1, mk(1, s), 8'h41, 0, -1, 0, 0, "R3");      // now M
            snp(0, 1, mk(1, s), 1'b1, 1'b1, "R6");           // M -> O

            req(0, mk(2, s), 0, 0, 0, 0, 0, "R2");           // E
            snp(0, 1, mk(2, s), 1'b1, 1'b0, "R6");           // E -> S, no supply
            req(1, mk(2, s), 8'h50, 0, 1, 0, 0, "R6");       // S store -> invalidate
            req(1, mk(3, s), 8'h60, 0, 1, 0, 0, "R5");       // store miss -> invalidate
            req(1, mk(3, s), 8'h61, 0, -1, 0, 0, "R5");      // now M
            req(0, mk(4, s), 0, 1, 0, 0, 0, "R2");           // S, set full

            req(0, mk(5, s), 0, 0, 0, 1, mk(1, s), "R11");   // evicts owned tag1
            req(0, mk(6, s), 0, 0, 0, 1, mk(2, s), "R11");   // evicts modified tag2
            req(0, mk(3, s), 0, 0, -1, 0, 0, "R10");         // tag3 kept
            req(0, mk(7, s), 0, 0, 0, 0, 0, "R11");          // evicts shared tag4
            req(0, mk(1, s), 0, 0, 0, 0, 0, "R10");          // evicts exclusive tag5
            req(1, mk(6, s), 8'h70, 0, -1, 0, 0, "R3");      // E -> M
            snp(1, 2, mk(7, s), 1'b1, 1'b0, "R7");           // frees tag7's way
            req(0, mk(8, s), 0, 0, 0, 0, 0, "R10");          // free way, not dirty LRU
            req(0, mk(3, s), 0, 0, -1, 0, 0, "R10");         // tag3 survived
        end

        @(negedge clk);
        chk("R12", "cnt_read", int'(cnt_read), e_rd);
        chk("R12", "cnt_inv", int'(cnt_inv), e_inv);
        chk("R12", "cnt_upd", int'(cnt_upd), e_upd);
        chk("R12", "cnt_wb", int'(cnt_wb), e_wb);
        chk("R12", "cnt_total", int'(cnt_total), e_rd + e_inv + e_upd + e_wb);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule